// File: doc/BRIEF.md
# Clock Prescaler with Selectable Rate Tap

This block turns a 32.768 kHz clock enable into the timing strobes a real-time clock needs. A 15-bit binary divider counts the enable pulses. A one-cycle tick marks each completed second, and it drives the time-of-day update logic downstream. One of thirteen divider stages is chosen by a 4-bit rate code. That stage feeds a square-wave pin and a periodic event strobe, which an interrupt controller can latch.

A three-bit oscillator control word, held in a register elsewhere, sets the run state. A small state machine has three states: `OSC_STOP` (oscillator off), `OSC_IDLE` (oscillator running, divider held cleared) and `OSC_RUN`. The word `010` selects `OSC_RUN`, `11x` selects `OSC_IDLE`, and any other value selects `OSC_STOP`. The machine moves to the decoded state on every clock. The transition from either of the other states into `OSC_RUN` is called *launch*. On launch the divider loads its half-way value, so the first one-second tick arrives half a second later. Leaving `OSC_RUN` is called *freeze* (to `OSC_IDLE`) or *halt* (to `OSC_STOP`). Moves between `OSC_IDLE` and `OSC_STOP` are *park* and *wake*.

Top module: `rtc_prescaler`

## Requirements
- R1: While rst_n is low, every output is 0, and after release the machine is in `OSC_STOP` with the divider cleared.
- R2: The state follows the previous cycle's osc_ctl: `010` gives `OSC_RUN`, `110`/`111` give `OSC_IDLE`, anything else gives `OSC_STOP`. Outside `OSC_RUN` the divider is held at zero and sqw_out, per_stb and sec_tick are 0.
- R3: On the launch transition the divider loads 16384 and ignores tick_en in that cycle. The first sec_tick therefore comes on the 16384th enable cycle spent in `OSC_RUN`, which is 500 ms.
- R4: sec_tick is high for exactly the enable cycle in which the divider steps from 32767 to 0. In steady running that is once every 32768 enables.
- R5: The divider advances by one only in `OSC_RUN` cycles with tick_en high. With tick_en low it holds, and no strobe or tick is produced.
- R6: Rate codes select a square-wave frequency. Codes 3 to 15 give 8192, 4096, 2048, 1024, 512, 256, 128, 64, 32, 16, 8, 4 and 2 Hz, which is 32768 >> (code-1). Code 1 gives 256 Hz and code 2 gives 128 Hz, the same as codes 8 and 9. The selected tap is divider bit b, where 2^(b+1) enables make one period.
- R7: Rate code 0 gives neither a square wave nor periodic strobes.
- R8: With sqw_en at 0, sqw_out is held at 0, and per_stb keeps running at the selected rate.
- R9: per_stb is high for the single enable cycle in which the selected tap bit goes from 0 to 1. The spacing between strobes is therefore 32768 / frequency enables, from 4 (122.07 µs) up to 16384 (500 ms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at 32.768 kHz |
| osc_ctl | input | 3 | Oscillator/divider control word |
| rate_sel | input | 4 | Rate code selecting the divider tap |
| sqw_en | input | 1 | Square-wave pin enable |
| sqw_out | output | 1 | Square wave from the selected tap, gated |
| per_stb | output | 1 | One-cycle periodic event strobe |
| sec_tick | output | 1 | One-cycle once-per-second update tick |

## Verification
The tick is first measured with the enable held high, which gives exact cycle counts. Those counts separate the half-second first interval from the full-second intervals that follow. Strobe spacing is then timed for codes 3, 1, 8, 2, 9, 12 and 15. This distinguishes the low aliased codes from the monotonic part of the table, and it exposes off-by-one tap selection. Directed windows use code 0, a disabled pin, a gap in the enable and the two non-running control patterns, and each shows one gate on its own. A seeded random phase mixes a sparse enable with changes of rate code and control word. A cycle model checks that phase, covering relaunch and rate changes in mid-period.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;

    typedef enum logic [1:0] {
        OSC_STOP = 2'd0,
        OSC_IDLE = 2'd1,
        OSC_RUN  = 2'd2
    } osc_state_e;

    localparam int RATE_W = 4;
    localparam int NCODE  = 1 << RATE_W;

    // divider bit index driven out for a given rate code (code 0 unused)
    function automatic int tap_of(input int code);
        if (code == 0)
            return 0;
        else if (code < 3)
            return code + 5;
        else
            return code - 2;
    endfunction

endpackage

// File: rtl/rtc_osc_fsm.sv
module rtc_osc_fsm
    import rtc_pre_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] osc_ctl,
    output osc_state_e state_q,
    output logic       run,
    output logic       start
);

    osc_state_e state_d;

    // decode of the control word into the target state
    always_comb begin
        unique case (osc_ctl)
            3'b010:         state_d = OSC_RUN;
            3'b110, 3'b111: state_d = OSC_IDLE;
            default:        state_d = OSC_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= OSC_STOP;
        else
            state_q <= state_d;
    end

    // launch = any non-run state heading into OSC_RUN
    always_comb begin
        run   = 1'b0;
        start = 1'b0;
        unique case (state_q)
            OSC_STOP: start = (state_d == OSC_RUN);
            OSC_IDLE: start = (state_d == OSC_RUN);
            OSC_RUN:  run   = 1'b1;
            default:  start = 1'b0;
        endcase
    end

    assert_launch_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == OSC_RUN));

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             tick_en,
    output logic [DIV_W-1:0] cnt,
    output logic             sec_tick
);

    localparam logic [DIV_W-1:0] HALF = {1'b1, {(DIV_W-1){1'b0}}};
    localparam logic [DIV_W-1:0] TOP  = {DIV_W{1'b1}};
    localparam logic [DIV_W-1:0] STEP = {{(DIV_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= HALF;
        else if (!run)
            cnt <= '0;
        else if (tick_en)
            cnt <= cnt + STEP;
    end

    assign sec_tick = run && tick_en && (cnt == TOP);

    assert_preload_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == HALF));

    assert_hold_without_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_en) |=> $stable(cnt));

    assert_tick_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (cnt == '0));

endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
    import rtc_pre_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cnt,
    input  logic              run,
    input  logic              tick_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    output logic              sqw_out,
    output logic              per_stb
);

    localparam logic [DIV_W-1:0] STEP = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_nx;
    logic [NCODE-1:0] cur_vec;
    logic [NCODE-1:0] nxt_vec;
    logic             cur_tap;
    logic             nxt_tap;
    logic             code_on;

    assign cnt_nx = cnt + STEP;

    for (genvar c = 0; c < NCODE; c++) begin : g_tap
        if (c == 0) begin : g_none
            assign cur_vec[c] = 1'b0;
            assign nxt_vec[c] = 1'b0;
        end else begin : g_pick
            localparam int TI = tap_of(c);
            assign cur_vec[c] = cnt[TI];
            assign nxt_vec[c] = cnt_nx[TI];
        end
    end

    assign cur_tap = cur_vec[rate_sel];
    assign nxt_tap = nxt_vec[rate_sel];
    assign code_on = (rate_sel != '0);

    assign sqw_out = run && sqw_en && code_on && cur_tap;
    assign per_stb = run && code_on && tick_en && nxt_tap && !cur_tap;

    assert_strobe_marks_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb |=> (!$stable(rate_sel) || cur_tap));

    assert_code_zero_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |-> (!per_stb && !sqw_out));

    assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |-> !sqw_out);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pre_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] osc_ctl,
    input  logic [3:0] rate_sel,
    input  logic       sqw_en,
    output logic       sqw_out,
    output logic       per_stb,
    output logic       sec_tick
);

    osc_state_e       state_q;
    logic             run;
    logic             start;
    logic [DIV_W-1:0] cnt;

    rtc_osc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_ctl (osc_ctl),
        .state_q (state_q),
        .run     (run),
        .start   (start)
    );

    rtc_div_chain #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .start    (start),
        .tick_en  (tick_en),
        .cnt      (cnt),
        .sec_tick (sec_tick)
    );

    rtc_tap_sel #(.DIV_W(DIV_W)) u_tap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .run      (run),
        .tick_en  (tick_en),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .sqw_out  (sqw_out),
        .per_stb  (per_stb)
    );

    assert_quiet_unless_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osc_ctl) != 3'b010) |-> (!sqw_out && !per_stb && !sec_tick));

endmodule

// File: tb/rtc_prescaler_tb.sv
module rtc_prescaler_tb;

    localparam int CLK_NS   = 10;
    localparam int WD_LIMIT = 190000;
    localparam int SEED     = 24681;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] osc_ctl = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       sqw_en = 1'b0;
    logic       sqw_out, per_stb, sec_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic        m_run = 1'b0;
    logic [14:0] m_cnt = '0;

    rtc_prescaler u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .osc_ctl  (osc_ctl),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .sqw_out  (sqw_out),
        .per_stb  (per_stb),
        .sec_tick (sec_tick)
    );

    always #(CLK_NS/2) clk = ~clk;

    // enables per square-wave period for a rate code (R6)
    function automatic int per_len(input logic [3:0] code);
        if (code == 4'd0) return 0;
        if (code == 4'd1) return 128;
        if (code == 4'd2) return 256;
        return 1 << (int'(code) - 1);
    endfunction

    function automatic int bit_of(input logic [3:0] code);
        int p = per_len(code);
        for (int b = 0; b < 15; b++)
            if ((2 << b) == p) return b;
        return 0;
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%0b expected=%0b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // reference model, updated from the previous cycle's inputs
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_run <= 1'b0;
            m_cnt <= '0;
        end else if (!m_run) begin
            if (osc_ctl == 3'b010) begin
                m_run <= 1'b1;
                m_cnt <= 15'd16384;
            end else begin
                m_cnt <= '0;
            end
        end else begin
            if (tick_en) m_cnt <= m_cnt + 15'd1;
            m_run <= (osc_ctl == 3'b010);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int          b;
            logic [14:0] nx;
            logic        e_tick, e_per, e_sqw;
            b      = bit_of(rate_sel);
            nx     = m_cnt + 15'd1;
            e_tick = m_run && tick_en && (m_cnt == 15'h7fff);
            e_per  = m_run && (rate_sel != 0) && tick_en && nx[b] && !m_cnt[b];
            e_sqw  = m_run && sqw_en && (rate_sel != 0) && m_cnt[b];
            check(sec_tick, e_tick, "R4 sec_tick vs model");
            check(per_stb, e_per, "R9 per_stb vs model");
            check(sqw_out, e_sqw, "R6 sqw_out vs model");
        end
        if (cyc > WD_LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got=%0d cycles expected<=%0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic measure_period(input logic [3:0] code);
        int n;
        int guard;
        step();
        rate_sel = code;
        tick_en  = 1'b1;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!per_stb && guard < 40000);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!per_stb && n < 40000);
        check_int(n, per_len(code), $sformatf("R9 strobe spacing code %0d", code));
    endtask

    initial begin
        int n;
        int hi_any;
        int stb;
        int flips;
        logic last;
        void'($urandom(SEED));

        // R1: outputs low under reset
        repeat (4) begin
            @(negedge clk);
            check(sqw_out | per_stb | sec_tick, 1'b0, "R1 outputs during reset");
        end
        step();
        rst_n = 1'b1;

        // R2: stopped and idle patterns keep everything low
        rate_sel = 4'd3; sqw_en = 1'b1; tick_en = 1'b1; osc_ctl = 3'b000;
        hi_any = 0;
        repeat (60) begin @(negedge clk); if (sqw_out | per_stb | sec_tick) hi_any++; end
        check_int(hi_any, 0, "R2 stop pattern quiet");
        step(); osc_ctl = 3'b110;
        hi_any = 0;
        repeat (60) begin @(negedge clk); if (sqw_out | per_stb | sec_tick) hi_any++; end
        check_int(hi_any, 0, "R2 idle pattern quiet");

        // R3: first tick half a second after launch
        step(); osc_ctl = 3'b010;
        @(posedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!sec_tick && n < 40000);
        check_int(n, 16384, "R3 first tick enables");
        // R4: full second afterwards
        n = 0;
        do begin @(negedge clk); n++; end while (!sec_tick && n < 40000);
        check_int(n, 32768, "R4 second tick enables");

        // R6 / R9: strobe spacing for aliased and monotonic codes
        measure_period(4'd3);
        measure_period(4'd1);
        measure_period(4'd8);
        measure_period(4'd2);
        measure_period(4'd9);
        measure_period(4'd12);
        measure_period(4'd15);

        // R7: code zero silent
        step(); rate_sel = 4'd0; sqw_en = 1'b1;
        hi_any = 0;
        repeat (300) begin @(negedge clk); if (sqw_out | per_stb) hi_any++; end
        check_int(hi_any, 0, "R7 code zero silent");

        // R8: pin gated, strobes continue
        step(); rate_sel = 4'd3; sqw_en = 1'b0;
        hi_any = 0; stb = 0;
        repeat (100) begin @(negedge clk); if (sqw_out) hi_any++; if (per_stb) stb++; end
        check_int(hi_any, 0, "R8 sqw held low");
        check_int(stb, 25, "R8 strobes still running");

        // R5: no enable, no progress
        step(); sqw_en = 1'b1; tick_en = 1'b0;
        @(negedge clk);
        last = sqw_out; hi_any = 0; flips = 0;
        repeat (100) begin
            @(negedge clk);
            if (per_stb | sec_tick) hi_any++;
            if (sqw_out != last) flips++;
            last = sqw_out;
        end
        check_int(hi_any, 0, "R5 no strobes without enable");
        check_int(flips, 0, "R5 square wave frozen");

        // random phase: sparse enable, rate and control changes (R5, R6, R9, R2)
        for (int k = 0; k < 4000; k++) begin
            step();
            tick_en = 1'($urandom % 2);
            if (k % 250 == 0) begin
                rate_sel = 4'($urandom % 16);
                sqw_en   = 1'($urandom % 4 != 0);
            end
            if (k % 97 == 0) begin
                case ($urandom % 6)
                    0: osc_ctl = 3'b110;
                    1: osc_ctl = 3'b000;
                    2: osc_ctl = 3'b111;
                    default: osc_ctl = 3'b010;
                endcase
            end
        end
        step();
        step();
        summary();
    end

endmodule